// File: doc/BRIEF.md
# Chroma Upsampler with Colour Conversion

This block turns one row of half-horizontal-resolution YUV data into full-resolution 8-bit RGB pixels. A `start` pulse makes it fetch the row through a single byte-wide read port: every luma sample, then the U plane, then the V plane. Once the row is held locally, a pair engine makes one even/odd pixel pair per pass. The even pixel takes its chroma straight from the stored sample. The odd pixel gets its chroma from a symmetric ten-tap interpolation filter. Both pixels then go through a constant 3x3 colour matrix, are rounded and are clipped.

All multiplications, filter taps and matrix terms alike, run on four shared multipliers under a fixed five-phase schedule. Each phase fills all four units, and the luma product of each pixel is formed once and shared by its R, G and B sums. Results leave as an RGB triplet with a one-cycle valid strobe. A row-done pulse marks the final pixel.

The loader FSM has three states. In LD_IDLE it waits: a `start` seen while the pair engine is idle moves it to LD_FETCH. LD_FETCH holds a request until read data is valid, stores the byte and advances. After the last byte it moves to LD_DONE, which lasts one cycle, hands the row to the engine and returns to LD_IDLE. The engine FSM has six states. In PH_IDLE it waits for the handover and then enters PH_S0. It steps PH_S0 to PH_S1 to PH_S2 to PH_S3 to PH_S4 for each pair. From PH_S4 it goes back to PH_S0 for the next pair, or to PH_IDLE after the last pair.

Top module: `upcsc_row`

## Requirements
- R1: During and right after reset, `rd_req`, `pix_valid` and `row_done` are low.
- R2: After `start`, the block reads addresses 0 to 2·ROW_PIX−1 once each, in rising order, with luma sample x at address x, U sample j at ROW_PIX+j and V sample j at ROW_PIX+ROW_PIX/2+j. No read request is raised while pixels are being output.
- R3: Output pixel 2j uses U[j] and V[j] unchanged as its chroma.
- R4: Output pixel 2j+1 uses the filtered chroma sat8((Σk c_k·(C[j−4+k]+C[j+5−k]) + 128) >> 8), with c = (3, −9, 22, −48, 160) for k = 0..4, computed separately for U and V.
- R5: A filter tap index below 0 reads sample 0, and one above ROW_PIX/2−1 reads the last sample.
- R6: With y = Y−16, u = U−128 and v = V−128: R = (76284y + 104595v + 32768) >> 16, G = (76284y − 25624u − 53281v + 32768) >> 16, B = (76284y + 132251u + 32768) >> 16, all with arithmetic shifts.
- R7: Every R, G and B result, and every filtered chroma value, is clipped to 0..255.
- R8: Pixels leave in order, as pairs: the even pixel, the odd pixel on the next cycle, and the next even pixel five cycles after the previous one. From the first pixel to the last pixel of a row takes 5·(ROW_PIX/2−1)+1 cycles.
- R9: While `rd_req` is high and `rd_valid` is low, the request and `rd_addr` hold on the next cycle, so no sample is dropped or read twice.
- R10: `row_done` pulses once per row, in the same cycle as the valid strobe of pixel ROW_PIX−1, and exactly ROW_PIX pixels are output per row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a row (taken only when idle) |
| rd_req | output | 1 | Read request to row memory |
| rd_addr | output | $clog2(2·ROW_PIX) | Byte address of the requested sample |
| rd_data | input | 8 | Read data |
| rd_valid | input | 1 | Read data valid for the current address |
| pix_valid | output | 1 | RGB triplet valid strobe |
| pix_r | output | 8 | Red |
| pix_g | output | 8 | Green |
| pix_b | output | 8 | Blue |
| row_done | output | 1 | Last pixel of the row |

## Verification
Random rows with random read latency exercise the filter and the matrix on arbitrary data, and they catch samples that are dropped or duplicated under stalls. Linear chroma ramps have known interior midpoints, so a wrong coefficient or tap order shows up, and the ramp ends show whether edge taps replicate or wrap. A single bright chroma sample at each row end isolates the edge clamping. Rows built only from 0 and 255 push every channel past both clip limits and separate correct saturation from wrap-around.

// File: rtl/upcsc_pkg.sv
package upcsc_pkg;

    localparam int NUM_MUL   = 4;
    localparam int MUL_A_W   = 19;
    localparam int MUL_B_W   = 10;
    localparam int PROD_W    = 32;
    localparam int FIR_PAIRS = 5;

    localparam int K_LUMA = 76284;
    localparam int K_RV   = 104595;
    localparam int K_GU   = -25624;
    localparam int K_GV   = -53281;
    localparam int K_BU   = 132251;

    typedef enum logic [1:0] {LD_IDLE, LD_FETCH, LD_DONE} load_state_t;
    typedef enum logic [2:0] {PH_IDLE, PH_S0, PH_S1, PH_S2, PH_S3, PH_S4} pair_phase_t;

    // Coefficient for the tap pair k, where k=0 is the outermost pair.
    function automatic int fir_coef(input int k);
        case (k)
            0:       return 3;
            1:       return -9;
            2:       return 22;
            3:       return -48;
            default: return 160;
        endcase
    endfunction

    function automatic logic [7:0] sat_u8(input logic signed [PROD_W-1:0] x);
        if (x < 0)         return 8'd0;
        else if (x > 255)  return 8'd255;
        else               return x[7:0];
    endfunction

    function automatic logic [7:0] chroma_round(input logic signed [PROD_W-1:0] x);
        logic signed [PROD_W-1:0] t;
        t = (x + 32'sd128) >>> 8;
        return sat_u8(t);
    endfunction

    function automatic logic [7:0] rgb_round(input logic signed [PROD_W-1:0] x);
        logic signed [PROD_W-1:0] t;
        t = (x + 32'sd32768) >>> 16;
        return sat_u8(t);
    endfunction

endpackage

// File: rtl/upcsc_mul_bank.sv
module upcsc_mul_bank
    import upcsc_pkg::*;
(
    input  logic [NUM_MUL-1:0][MUL_A_W-1:0] op_a,
    input  logic [NUM_MUL-1:0][MUL_B_W-1:0] op_b,
    output logic [NUM_MUL-1:0][PROD_W-1:0]  prod
);
    for (genvar g = 0; g < NUM_MUL; g++) begin : g_mul
        logic signed [PROD_W-1:0] ext_a;
        logic signed [PROD_W-1:0] ext_b;
        assign ext_a   = PROD_W'($signed(op_a[g]));
        assign ext_b   = PROD_W'($signed(op_b[g]));
        assign prod[g] = ext_a * ext_b;
    end
endmodule

// File: rtl/upcsc_row_loader.sv
module upcsc_row_loader
    import upcsc_pkg::*;
#(
    parameter int ROW_PIX = 320
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    output logic                          rd_req,
    output logic [$clog2(2*ROW_PIX)-1:0]  rd_addr,
    input  logic [7:0]                    rd_data,
    input  logic                          rd_valid,
    output logic                          load_done,
    input  logic [$clog2(ROW_PIX/2)-1:0]  pair_idx,
    output logic [7:0]                    y_even,
    output logic [7:0]                    y_odd,
    output logic [7:0]                    u_cur,
    output logic [7:0]                    v_cur,
    output logic [FIR_PAIRS-1:0][8:0]     u_pair,
    output logic [FIR_PAIRS-1:0][8:0]     v_pair
);
    localparam int NC    = ROW_PIX / 2;
    localparam int JW    = $clog2(NC);
    localparam int YIW   = JW + 1;
    localparam int AW    = $clog2(2*ROW_PIX);
    localparam int LAST  = 2*ROW_PIX - 1;

    load_state_t st, st_nxt;
    logic [AW-1:0] cnt;
    logic [7:0] ybuf [ROW_PIX];
    logic [7:0] ubuf [NC];
    logic [7:0] vbuf [NC];

    function automatic logic [JW-1:0] clamp_idx(input int v);
        if (v < 0)            return '0;
        else if (v > NC - 1)  return JW'(NC - 1);
        else                  return JW'(v);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) st <= LD_IDLE;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            LD_IDLE:  if (start) st_nxt = LD_FETCH;
            LD_FETCH: if (rd_valid && cnt == AW'(LAST)) st_nxt = LD_DONE;
            LD_DONE:  st_nxt = LD_IDLE;
            default:  st_nxt = LD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                          cnt <= '0;
        else if (st != LD_FETCH)             cnt <= '0;
        else if (rd_valid)                   cnt <= cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (st == LD_FETCH && rd_valid) begin
            if (cnt < AW'(ROW_PIX))
                ybuf[YIW'(cnt)] <= rd_data;
            else if (cnt < AW'(ROW_PIX + NC))
                ubuf[JW'(cnt - AW'(ROW_PIX))] <= rd_data;
            else
                vbuf[JW'(cnt - AW'(ROW_PIX + NC))] <= rd_data;
        end
    end

    assign rd_req    = (st == LD_FETCH);
    assign rd_addr   = cnt;
    assign load_done = (st == LD_DONE);

    assign y_even = ybuf[{pair_idx, 1'b0}];
    assign y_odd  = ybuf[{pair_idx, 1'b1}];
    assign u_cur  = ubuf[pair_idx];
    assign v_cur  = vbuf[pair_idx];

    for (genvar k = 0; k < FIR_PAIRS; k++) begin : g_tap
        logic [JW-1:0] lo_i, hi_i;
        assign lo_i = clamp_idx(int'(pair_idx) - (FIR_PAIRS - 1) + k);
        assign hi_i = clamp_idx(int'(pair_idx) + FIR_PAIRS - k);
        assign u_pair[k] = {1'b0, ubuf[lo_i]} + {1'b0, ubuf[hi_i]};
        assign v_pair[k] = {1'b0, vbuf[lo_i]} + {1'b0, vbuf[hi_i]};
    end

    // R9: an unanswered request keeps its address
    assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

    // R2: addresses only move forward by one per accepted byte
    assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_valid && st_nxt == LD_FETCH) |=> (rd_addr == $past(rd_addr) + 1'b1));
endmodule

// File: rtl/upcsc_pair_engine.sv
module upcsc_pair_engine
    import upcsc_pkg::*;
#(
    parameter int ROW_PIX = 320
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load_done,
    input  logic [7:0]                    y_even,
    input  logic [7:0]                    y_odd,
    input  logic [7:0]                    u_cur,
    input  logic [7:0]                    v_cur,
    input  logic [FIR_PAIRS-1:0][8:0]     u_pair,
    input  logic [FIR_PAIRS-1:0][8:0]     v_pair,
    input  logic [NUM_MUL-1:0][PROD_W-1:0] prod,
    output logic [NUM_MUL-1:0][MUL_A_W-1:0] op_a,
    output logic [NUM_MUL-1:0][MUL_B_W-1:0] op_b,
    output logic [$clog2(ROW_PIX/2)-1:0]  pair_idx,
    output logic                          idle,
    output logic                          pix_valid,
    output logic [7:0]                    pix_r,
    output logic [7:0]                    pix_g,
    output logic [7:0]                    pix_b,
    output logic                          row_done
);
    localparam int NC = ROW_PIX / 2;
    localparam int JW = $clog2(NC);

    pair_phase_t ph, ph_nxt;

    logic signed [PROD_W-1:0] m0, m1, m2, m3;
    logic signed [PROD_W-1:0] acc_u, acc_v, p_y0, p_rv0, p_y1;
    logic [7:0] u_odd, v_odd;
    logic signed [MUL_B_W-1:0] y0d, y1d, u0d, v0d, u1d, v1d;
    logic last_pair;

    assign m0 = $signed(prod[0]);
    assign m1 = $signed(prod[1]);
    assign m2 = $signed(prod[2]);
    assign m3 = $signed(prod[3]);

    assign y0d = $signed({2'b00, y_even}) - 10'sd16;
    assign y1d = $signed({2'b00, y_odd})  - 10'sd16;
    assign u0d = $signed({2'b00, u_cur})  - 10'sd128;
    assign v0d = $signed({2'b00, v_cur})  - 10'sd128;
    assign u1d = $signed({2'b00, u_odd})  - 10'sd128;
    assign v1d = $signed({2'b00, v_odd})  - 10'sd128;

    assign last_pair = (pair_idx == JW'(NC - 1));
    assign idle      = (ph == PH_IDLE);

    always_ff @(posedge clk) begin
        if (!rst_n) ph <= PH_IDLE;
        else        ph <= ph_nxt;
    end

    always_comb begin
        ph_nxt = ph;
        unique case (ph)
            PH_IDLE: if (load_done) ph_nxt = PH_S0;
            PH_S0:   ph_nxt = PH_S1;
            PH_S1:   ph_nxt = PH_S2;
            PH_S2:   ph_nxt = PH_S3;
            PH_S3:   ph_nxt = PH_S4;
            PH_S4:   ph_nxt = last_pair ? PH_IDLE : PH_S0;
            default: ph_nxt = PH_IDLE;
        endcase
    end

    // Static multiplier schedule: all four units busy in every active phase.
    always_comb begin
        op_a = '0;
        op_b = '0;
        unique case (ph)
            PH_S0: begin
                for (int k = 0; k < NUM_MUL; k++) begin
                    op_a[k] = MUL_A_W'(fir_coef(k));
                    op_b[k] = {1'b0, u_pair[k]};
                end
            end
            PH_S1: begin
                op_a[0] = MUL_A_W'(fir_coef(4)); op_b[0] = {1'b0, u_pair[4]};
                op_a[1] = MUL_A_W'(fir_coef(0)); op_b[1] = {1'b0, v_pair[0]};
                op_a[2] = MUL_A_W'(fir_coef(1)); op_b[2] = {1'b0, v_pair[1]};
                op_a[3] = MUL_A_W'(fir_coef(2)); op_b[3] = {1'b0, v_pair[2]};
            end
            PH_S2: begin
                op_a[0] = MUL_A_W'(fir_coef(3)); op_b[0] = {1'b0, v_pair[3]};
                op_a[1] = MUL_A_W'(fir_coef(4)); op_b[1] = {1'b0, v_pair[4]};
                op_a[2] = MUL_A_W'(K_LUMA);      op_b[2] = y0d;
                op_a[3] = MUL_A_W'(K_RV);        op_b[3] = v0d;
            end
            PH_S3: begin
                op_a[0] = MUL_A_W'(K_GU);        op_b[0] = u0d;
                op_a[1] = MUL_A_W'(K_GV);        op_b[1] = v0d;
                op_a[2] = MUL_A_W'(K_BU);        op_b[2] = u0d;
                op_a[3] = MUL_A_W'(K_LUMA);      op_b[3] = y1d;
            end
            PH_S4: begin
                op_a[0] = MUL_A_W'(K_RV);        op_b[0] = v1d;
                op_a[1] = MUL_A_W'(K_GU);        op_b[1] = u1d;
                op_a[2] = MUL_A_W'(K_GV);        op_b[2] = v1d;
                op_a[3] = MUL_A_W'(K_BU);        op_b[3] = u1d;
            end
            default: begin
                op_a = '0;
                op_b = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_u     <= '0;
            acc_v     <= '0;
            p_y0      <= '0;
            p_rv0     <= '0;
            p_y1      <= '0;
            u_odd     <= '0;
            v_odd     <= '0;
            pair_idx  <= '0;
            pix_valid <= 1'b0;
            pix_r     <= '0;
            pix_g     <= '0;
            pix_b     <= '0;
            row_done  <= 1'b0;
        end else begin
            pix_valid <= 1'b0;
            row_done  <= 1'b0;
            unique case (ph)
                PH_IDLE: if (load_done) pair_idx <= '0;
                PH_S0:   acc_u <= m0 + m1 + m2 + m3;
                PH_S1: begin
                    u_odd <= chroma_round(acc_u + m0);
                    acc_v <= m1 + m2 + m3;
                end
                PH_S2: begin
                    v_odd <= chroma_round(acc_v + m0 + m1);
                    p_y0  <= m2;
                    p_rv0 <= m3;
                end
                PH_S3: begin
                    pix_r     <= rgb_round(p_y0 + p_rv0);
                    pix_g     <= rgb_round(p_y0 + m0 + m1);
                    pix_b     <= rgb_round(p_y0 + m2);
                    p_y1      <= m3;
                    pix_valid <= 1'b1;
                end
                PH_S4: begin
                    pix_r     <= rgb_round(p_y1 + m0);
                    pix_g     <= rgb_round(p_y1 + m1 + m2);
                    pix_b     <= rgb_round(p_y1 + m3);
                    pix_valid <= 1'b1;
                    row_done  <= last_pair;
                    pair_idx  <= pair_idx + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R8: an even pixel is always followed by its odd partner
    assert_odd_follows_even_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pix_valid) |=> pix_valid);

    // R8: never more than two strobes back to back
    assert_pair_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && $past(pix_valid)) |=> !pix_valid);

    // R10: completion marks a pixel and leaves the engine idle
    assert_done_on_pixel_R10: assert property (@(posedge clk) disable iff (!rst_n)
        row_done |-> (pix_valid && idle));
endmodule

// File: rtl/upcsc_row.sv
module upcsc_row
    import upcsc_pkg::*;
#(
    parameter int ROW_PIX = 320
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    output logic                          rd_req,
    output logic [$clog2(2*ROW_PIX)-1:0]  rd_addr,
    input  logic [7:0]                    rd_data,
    input  logic                          rd_valid,
    output logic                          pix_valid,
    output logic [7:0]                    pix_r,
    output logic [7:0]                    pix_g,
    output logic [7:0]                    pix_b,
    output logic                          row_done
);
    localparam int NC = ROW_PIX / 2;
    localparam int JW = $clog2(NC);

    logic load_done, eng_idle;
    logic [JW-1:0] pair_idx;
    logic [7:0] y_even, y_odd, u_cur, v_cur;
    logic [FIR_PAIRS-1:0][8:0] u_pair, v_pair;
    logic [NUM_MUL-1:0][MUL_A_W-1:0] op_a;
    logic [NUM_MUL-1:0][MUL_B_W-1:0] op_b;
    logic [NUM_MUL-1:0][PROD_W-1:0]  prod;

    upcsc_row_loader #(.ROW_PIX(ROW_PIX)) i_loader (
        .clk(clk), .rst_n(rst_n), .start(start && eng_idle),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
        .load_done(load_done), .pair_idx(pair_idx),
        .y_even(y_even), .y_odd(y_odd), .u_cur(u_cur), .v_cur(v_cur),
        .u_pair(u_pair), .v_pair(v_pair)
    );

    upcsc_mul_bank i_mul (.op_a(op_a), .op_b(op_b), .prod(prod));

    upcsc_pair_engine #(.ROW_PIX(ROW_PIX)) i_engine (
        .clk(clk), .rst_n(rst_n), .load_done(load_done),
        .y_even(y_even), .y_odd(y_odd), .u_cur(u_cur), .v_cur(v_cur),
        .u_pair(u_pair), .v_pair(v_pair), .prod(prod),
        .op_a(op_a), .op_b(op_b), .pair_idx(pair_idx), .idle(eng_idle),
        .pix_valid(pix_valid), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
        .row_done(row_done)
    );

    // R2: fetching and pixel output never overlap
    assert_no_fetch_during_output_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> !rd_req);

    // R1: quiet outputs on the first cycle after reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!pix_valid && !row_done && !rd_req));
endmodule

// File: tb/test_upcsc_row.sv
module test_upcsc_row;
    localparam int W  = 320;
    localparam int NC = W / 2;
    localparam int AW = $clog2(2*W);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic rd_req, rd_valid, pix_valid, row_done;
    logic [AW-1:0] rd_addr;
    logic [7:0] rd_data, pix_r, pix_g, pix_b;

    int checks = 0, errors = 0;
    int lat_max = 0, wcnt = 0, exp_addr = 0;
    int pidx = 0, cyc = 0, first_cyc = 0, last_cyc = 0;
    bit done_seen = 1'b0;
    string tag = "R3 R4 R6";
    logic [7:0] mem [2*W];

    always #10 clk = ~clk;

    upcsc_row #(.ROW_PIX(W)) i_upcsc_row (
        .clk(clk), .rst_n(rst_n), .start(start),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
        .pix_valid(pix_valid), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
        .row_done(row_done)
    );

    function automatic int sat(int x);
        return (x < 0) ? 0 : ((x > 255) ? 255 : x);
    endfunction

    function automatic int cl(int v);
        return (v < 0) ? 0 : ((v > NC - 1) ? NC - 1 : v);
    endfunction

    // R4 R5: filtered chroma for the odd pixel of pair j (plane base b)
    function automatic int filt(int j, int b);
        int c[5] = '{3, -9, 22, -48, 160};
        int s = 0;
        for (int k = 0; k < 5; k++)
            s += c[k] * (int'(mem[b + cl(j - 4 + k)]) + int'(mem[b + cl(j + 5 - k)]));
        return sat((s + 128) >>> 8);
    endfunction

    function automatic logic [23:0] ref_pix(int x);
        int j = x / 2, y, u, v;
        y = int'(mem[x]) - 16;
        if (x % 2 == 0) begin
            u = int'(mem[W + j]) - 128;
            v = int'(mem[W + NC + j]) - 128;
        end else begin
            u = filt(j, W) - 128;
            v = filt(j, W + NC) - 128;
        end
        return {8'(sat((76284*y + 104595*v + 32768) >>> 16)),
                8'(sat((76284*y - 25624*u - 53281*v + 32768) >>> 16)),
                8'(sat((76284*y + 132251*u + 32768) >>> 16))};
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Memory model with random latency; R2 R9 address order check
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            rd_valid <= 1'b0;
            wcnt = 0;
        end else if (rd_valid) begin
            rd_valid <= 1'b0;
        end else if (rd_req) begin
            if (wcnt == 0) begin
                rd_valid <= 1'b1;
                rd_data  <= mem[rd_addr];
                check(int'(rd_addr) == exp_addr, "R2 R9 read address", int'(rd_addr), exp_addr);
                exp_addr++;
                wcnt = $urandom % (lat_max + 1);
            end else begin
                wcnt--;
            end
        end
    end

    // Output monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n && row_done) begin
            check(pix_valid && pidx == W - 1, "R10 row_done on last pixel", pidx, W - 1);
            last_cyc = cyc;
            done_seen = 1'b1;
        end
        if (rst_n && pix_valid) begin
            logic [23:0] e;
            e = ref_pix(pidx);
            if (pidx == 0) first_cyc = cyc;
            check({pix_r, pix_g, pix_b} == e,
                  $sformatf("%s pixel %0d rgb", tag, pidx), int'({pix_r, pix_g, pix_b}), int'(e));
            pidx++;
        end
    end

    task automatic run_row(string t, int lat);
        tag = t; lat_max = lat;
        pidx = 0; exp_addr = 0; done_seen = 1'b0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int n = 0; n < 40000 && !done_seen; n++) @(negedge clk);
        if (!done_seen) check(1'b0, "watchdog", 0, 1);
        @(negedge clk);
        check(pidx == W, "R10 pixel count", pidx, W);
        check(exp_addr == 2*W, "R2 read count", exp_addr, 2*W);
        check(last_cyc - first_cyc == 5*(NC-1) + 1, "R8 row span", last_cyc - first_cyc, 5*(NC-1) + 1);
        repeat (3) @(negedge clk);
        check(!pix_valid && !rd_req, "R10 quiet after row", int'(pix_valid), 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!rd_req && !pix_valid && !row_done, "R1 reset outputs", int'({rd_req, pix_valid, row_done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!rd_req && !pix_valid && !row_done, "R1 after release", int'({rd_req, pix_valid, row_done}), 0);

        // Random row, random stalls (R3 R4 R6 R9)
        for (int i = 0; i < 2*W; i++) mem[i] = 8'($urandom);
        run_row("R3 R4 R6", 3);

        // Chroma ramps: interior midpoints, edges replicate (R4 R5)
        for (int i = 0; i < W; i++) mem[i] = 8'($urandom);
        for (int j = 0; j < NC; j++) begin
            mem[W + j] = 8'(j);
            mem[W + NC + j] = 8'(255 - j);
        end
        run_row("R4 R5", 0);

        // Single bright sample at each row end (R5)
        for (int i = 0; i < W; i++) mem[i] = 8'd128;
        for (int j = 0; j < NC; j++) begin
            mem[W + j] = 8'd128;
            mem[W + NC + j] = 8'd128;
        end
        mem[W] = 8'd255;
        mem[W + NC + NC - 1] = 8'd0;
        mem[W + NC - 1] = 8'd250;
        run_row("R5 edge", 1);

        // Extremes only: saturation on both limits (R7)
        for (int i = 0; i < 2*W; i++) mem[i] = ($urandom % 2) ? 8'd255 : 8'd0;
        run_row("R7 clip", 2);

        // Second random row with long stalls
        for (int i = 0; i < 2*W; i++) mem[i] = 8'($urandom);
        run_row("R3 R4 R6 R7", 4);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule